// File: doc/BRIEF.md
# SPI Master Controller with Word Queues and Register Window

This block is a master-only serial peripheral interface controller that software drives through an APB slave register window. Words written to the transmit register enter a transmit queue. Whenever the controller is enabled and that queue holds a word, the controller takes the word and shifts it out on the data-out pin. At the same time it samples the data-in pin, or its own output when loopback is selected. Each finished word goes into a receive queue, and software drains that queue through the receive register.

The serial clock comes from the bus clock through a programmable divider. Software selects the clock polarity, the clock phase, the bit order and the word length. There are no slave-select outputs; select lines are expected to come from general-purpose pins. Three sticky event flags, each gated by its own mask bit, combine into one interrupt line.

APB handshake: `pready` is always high, so every access completes in its access phase. Back-pressure is applied by dropping data rather than by stalling the bus:
- A write to a full transmit queue is discarded.
- A word that finishes while the receive queue is full is discarded.
- A read of an empty receive queue returns zero.

Top module: `spi_queue_master`

## Requirements
- R1: The register offsets are 0x00 capability, 0x20 mode, 0x24 event, 0x28 mask, 0x2C command, 0x30 transmit and 0x34 receive. The capability word is read-only and reads 0x0100_1002: slave-select count 1 in bits 31:24, slave-select present bit 16 = 0, queue depth 16 in bits 15:8, revision 2 in bits 7:0. In the mode register only bits 30:16, 13, 12 and 11:7 are stored; all other bits read zero. The command register reads zero and writes to it have no effect. After reset the mode and mask registers read zero.
- R2: Mode bit fields are: 30 loopback, 29 clock polarity, 28 clock phase, 27 extra divide-by-16, 26 MSB first, 25 master select, 24 enable, 23:20 length code, 19:16 prescale, 13 fast divider. A transfer starts by itself whenever enable is 1 and the transmit queue holds a word. While no transfer runs, the serial clock rests at the polarity value.
- R3: Each queue holds 17 words (depth 16 plus one). A transmit write to a full queue is dropped. A word completing while the receive queue is full is dropped. A receive read from an empty queue returns 0.
- R4: The serial clock period is (4 − 2·fast)·(prescale+1) bus clocks, multiplied by 16 when the divide-by-16 bit is set.
- R5: A length code L gives a word of L+1 bits; L=0 gives 32 bits.
- R6: With phase 0, the first data bit is on the data-out pin before the first clock edge. Data-in is sampled on leading edges and data-out changes on trailing edges. With phase 1, data-out changes on leading edges and data-in is sampled on trailing edges.
- R7: With the MSB-first bit set, bit L..0 is sent from the top down; otherwise it is sent from bit 0 up. Received words are right-aligned, with the upper bits at zero.
- R8: With loopback set, the receive side samples the block's own data-out and ignores the data-in pin.
- R9: While enable is 1, writes leave the divide-by-16, fast-divider and prescale fields unchanged, while the other mode fields still update.
- R10: The event register holds three flags: bit 9 set while the transmit queue is not full, bit 8 set while the receive queue is non-empty, and bit 14 set when a word completes with the transmit queue empty. Writing 1 to a bit clears it, but the flag is set again at once if its condition still holds.
- R11: The interrupt output is the OR of the event bits ANDed with the matching mask register bits (mask bits 14, 9 and 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| irq | output | 1 | Masked event interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The shifter is exercised with all four polarity and phase combinations against a bench slave that records data-out and drives its own pattern. The cases mix MSB-first and LSB-first order with word lengths of 5, 8, 12 and 32 bits, so a wrong edge choice, a reversed bit order or a wrong length each corrupts either the captured data-out sequence or the received word. Loopback runs hold data-in at both constant levels to show that the pin is ignored. The divider is measured with four prescale, fast and divide-by-16 settings chosen so that each factor changes the period by a different ratio. The queue test overfills both directions by exactly one word, which separates a capacity of 17 from 16 or 18.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFS_CAP  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h20;
  localparam logic [7:0] OFS_EV   = 8'h24;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_CMD  = 8'h2C;
  localparam logic [7:0] OFS_TX   = 8'h30;
  localparam logic [7:0] OFS_RX   = 8'h34;

  localparam int B_LOOP  = 30;
  localparam int B_CPOL  = 29;
  localparam int B_CPHA  = 28;
  localparam int B_DIV16 = 27;
  localparam int B_MSB   = 26;
  localparam int B_EN    = 24;
  localparam int B_FAST  = 13;

  localparam logic [31:0] MODE_WMASK = 32'h7FFF_3F80;
  localparam logic [31:0] MODE_LOCK  = 32'h080F_2000;

  localparam int EV_NE = 8;
  localparam int EV_NF = 9;
  localparam int EV_LT = 14;
  localparam logic [31:0] EV_BITS = 32'h0000_4300;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W   = 32,
  parameter int CAP = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(CAP);
  localparam int CW = $clog2(CAP + 1);

  logic [W-1:0]  mem [CAP];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(CAP - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(CAP));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R3: occupancy never exceeds the stated capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CAP));
  // R3: a push against a full queue without a pop leaves it full and unmoved
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wp)));
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PMW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           fast,
  input  logic           div16,
  input  logic [PMW-1:0] pm,
  output logic           tick
);
  localparam int HW = PMW + 6;

  logic [HW-1:0] cnt, half;

  // half period in bus clocks = (2 - fast) * (pm + 1) * (div16 ? 16 : 1)
  always_comb begin
    half = HW'(pm) + 1'b1;
    if (!fast) half = half << 1;
    if (div16) half = half << 4;
  end

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R4: the half-period counter stays inside the programmed window
  a_r4_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  word,
  input  logic [$clog2(W):0] nbits,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          msb,
  input  logic          loop,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [W-1:0]  rx_word
);
  localparam int IW = $clog2(W);
  localparam int EW = IW + 2;

  logic [W-1:0]  txw, rxw;
  logic [IW-1:0] idx, idx_n, first;
  logic [EW-1:0] edges;
  logic          lead, sample_now, in_bit;

  assign first      = msb ? IW'(nbits - 1'b1) : '0;
  assign idx_n      = msb ? idx - 1'b1 : idx + 1'b1;
  assign lead       = ~edges[0];
  assign sample_now = lead ^ cpha;
  assign in_bit     = loop ? mosi : miso;
  assign rx_word    = rxw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sck   <= 1'b0;
      mosi  <= 1'b0;
      done  <= 1'b0;
      txw   <= '0;
      rxw   <= '0;
      idx   <= '0;
      edges <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= cpol;
        if (start) begin
          busy  <= 1'b1;
          txw   <= word;
          rxw   <= '0;
          idx   <= first;
          edges <= '0;
          if (!cpha) mosi <= word[first];
        end
      end else if (tick) begin
        sck   <= ~sck;
        edges <= edges + 1'b1;
        if (sample_now) begin
          rxw[idx] <= in_bit;
          if (cpha) idx <= idx_n;
        end else if (cpha) begin
          mosi <= txw[idx];
        end else begin
          idx  <= idx_n;
          mosi <= txw[idx_n];
        end
        if ((edges + 1'b1) == {nbits, 1'b0}) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: with no transfer running, the clock follows the polarity setting
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (sck == $past(cpol)));
  // R6: the serial clock only moves on a divider tick
  a_r6_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int DEPTH    = 16,
  parameter int REVISION = 2
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  import spim_pkg::*;

  localparam int W   = 32;
  localparam int IW  = $clog2(W);
  localparam int CAP = DEPTH + 1;

  logic [31:0] mode_q, mask_q, ev_q, ev_set, ev_clr, cap_word;
  logic        wr, rd, en, start, busy, done, tick;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [W-1:0] tx_data, rx_data, rx_word;
  logic [3:0]  len;
  logic [IW:0] nbits;

  assign wr     = psel && penable && pwrite;
  assign rd     = psel && penable && !pwrite;
  assign pready = 1'b1;
  assign en     = mode_q[B_EN];
  assign len    = mode_q[23:20];
  assign nbits  = (len == 4'd0) ? (IW+1)'(W) : (IW+1)'(len) + 1'b1;
  assign start  = en && !tx_empty && !busy;
  assign cap_word = {8'd1, 4'd0, 3'd0, 1'b0, 8'(DEPTH), 8'(REVISION)};

  spim_fifo #(.W(W), .CAP(CAP)) u_txq (
    .clk(pclk), .rst_n(presetn),
    .push(wr && paddr == OFS_TX), .wdata(pwdata),
    .pop(start), .rdata(tx_data), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.W(W), .CAP(CAP)) u_rxq (
    .clk(pclk), .rst_n(presetn),
    .push(done), .wdata(rx_word),
    .pop(rd && paddr == OFS_RX), .rdata(rx_data), .empty(rx_empty), .full(rx_full));

  spim_clkgen #(.PMW(4)) u_div (
    .clk(pclk), .rst_n(presetn), .run(busy),
    .fast(mode_q[B_FAST]), .div16(mode_q[B_DIV16]), .pm(mode_q[19:16]), .tick(tick));

  spim_shift #(.W(W)) u_shift (
    .clk(pclk), .rst_n(presetn), .start(start), .word(tx_data), .nbits(nbits),
    .cpol(mode_q[B_CPOL]), .cpha(mode_q[B_CPHA]), .msb(mode_q[B_MSB]),
    .loop(mode_q[B_LOOP]), .tick(tick), .miso(miso),
    .busy(busy), .sck(sck), .mosi(mosi), .done(done), .rx_word(rx_word));

  always_comb begin
    ev_set        = '0;
    ev_set[EV_NF] = !tx_full;
    ev_set[EV_NE] = !rx_empty;
    ev_set[EV_LT] = done && tx_empty;
    ev_clr        = (wr && paddr == OFS_EV) ? pwdata : '0;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      mode_q <= '0;
      mask_q <= '0;
      ev_q   <= '0;
    end else begin
      ev_q <= ((ev_q & ~ev_clr) | ev_set) & EV_BITS;
      if (wr && paddr == OFS_MASK) mask_q <= pwdata & EV_BITS;
      if (wr && paddr == OFS_MODE) begin
        if (en) mode_q <= ((pwdata & ~MODE_LOCK) | (mode_q & MODE_LOCK)) & MODE_WMASK;
        else    mode_q <= pwdata & MODE_WMASK;
      end
    end
  end

  assign irq = |(ev_q & mask_q);

  always_comb begin
    case (paddr)
      OFS_CAP:  prdata = cap_word;
      OFS_MODE: prdata = mode_q;
      OFS_EV:   prdata = ev_q;
      OFS_MASK: prdata = mask_q;
      OFS_CMD:  prdata = '0;
      OFS_RX:   prdata = rx_empty ? '0 : rx_data;
      default:  prdata = '0;
    endcase
  end

  // R9: divider fields cannot move once enable was set on the previous edge
  a_r9_locked_divider: assert property (@(posedge pclk) disable iff (!presetn)
    en |=> ((mode_q & MODE_LOCK) == $past(mode_q & MODE_LOCK)));
  // R2: an enabled controller with queued data begins shifting next cycle
  a_r2_auto_start: assert property (@(posedge pclk) disable iff (!presetn)
    (en && !tx_empty && !busy) |=> busy);
  // R10: completion with an empty transmit queue raises the last-word flag
  a_r10_last_flag: assert property (@(posedge pclk) disable iff (!presetn)
    (done && tx_empty) |=> ev_q[EV_LT]);
  // R3: the receive queue never accepts while full (no word lost silently into it)
  a_r3_rx_bound: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_full && !(rd && paddr == OFS_RX)) |=> rx_full);
endmodule

// File: tb/spi_queue_master_bench.sv
`timescale 1ns/1ps
module spi_queue_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq, sck, mosi;
  logic        miso_r = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  // bench slave state
  logic        mon_on = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0, lead_b;
  logic [31:0] s_word = '0, m_cap = '0;
  int          s_cnt = 0, m_cnt = 0;

  localparam logic [7:0] A_CAP = 8'h00, A_MODE = 8'h20, A_EV = 8'h24,
                         A_MASK = 8'h28, A_CMD = 8'h2C, A_TX = 8'h30, A_RX = 8'h34;

  spi_queue_master u_spi_queue_master (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso_r));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(sck) begin
    if (mon_on) begin
      lead_b = (sck != cpol_b);
      if (lead_b ^ cpha_b) begin
        if (m_cnt < 32) m_cap[m_cnt] = mosi;
        m_cnt++;
      end else if (cpha_b) begin
        if (s_cnt < 32) miso_r = s_word[s_cnt];
        s_cnt++;
      end else begin
        s_cnt++;
        if (s_cnt < 32) miso_r = s_word[s_cnt];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] mk_mode(input logic loop, cpol, cpha, div16, msb, en,
                                          input int len, input int pm, input logic fast);
    logic [31:0] m;
    m = '0;
    m[30] = loop; m[29] = cpol; m[28] = cpha; m[27] = div16; m[26] = msb;
    m[25] = 1'b1; m[24] = en; m[23:20] = 4'(len); m[19:16] = 4'(pm); m[13] = fast;
    return m;
  endfunction

  // order in which a word's bits appear on the wire (element k = k-th bit)
  function automatic logic [31:0] wire_seq(input logic [31:0] w, input int n, input logic msb);
    logic [31:0] s;
    s = '0;
    for (int k = 0; k < n; k++) s[k] = msb ? w[n-1-k] : w[k];
    return s;
  endfunction

  function automatic logic [31:0] rx_expect(input logic [31:0] s, input int n, input logic msb);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[msb ? n-1-k : k] = s[k];
    return r;
  endfunction

  task automatic apply_mode(input logic [31:0] m);
    apb_write(A_MODE, m & ~32'h0100_0000);
    apb_write(A_MODE, m & ~32'h0100_0000);
    apb_write(A_MODE, m);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R2 sck idle after reset", {31'd0, sck}, 32'd0);
    chk("R11 irq low after reset", {31'd0, irq}, 32'd0);
    apb_read(A_CAP, d);  chk("R1 capability word", d, 32'h0100_1002);
    apb_read(A_MODE, d); chk("R1 mode reset", d, 32'h0);
    apb_read(A_MASK, d); chk("R1 mask reset", d, 32'h0);
    apb_read(A_EV, d);   chk("R10 not-full flag after reset", d, 32'h0000_0200);
    apb_write(A_CMD, 32'hFFFF_FFFF);
    apb_read(A_CMD, d);  chk("R1 command reads zero", d, 32'h0);
    apb_write(A_CAP, 32'hFFFF_FFFF);
    apb_read(A_CAP, d);  chk("R1 capability read-only", d, 32'h0100_1002);
    apb_write(A_MODE, 32'hFFFF_FFFF);
    apb_read(A_MODE, d); chk("R1 mode reserved bits", d, 32'h7FFF_3F80);
    apb_write(A_MODE, 32'h0);
    apb_read(A_MODE, d); chk("R9 locked fields kept while enabled", d, 32'h080F_2000);
    apb_write(A_MODE, 32'h0);
    apb_read(A_MODE, d); chk("R9 fields free once disabled", d, 32'h0);
  endtask

  task automatic run_xfer(input string tag, input logic cpol, cpha, msb, input int len,
                          input logic [31:0] txw, input logic [31:0] sw);
    int n;
    logic [31:0] d;
    n = (len == 0) ? 32 : len + 1;
    mon_on = 1'b0; cpol_b = cpol; cpha_b = cpha; s_word = sw;
    apply_mode(mk_mode(1'b0, cpol, cpha, 1'b0, msb, 1'b1, len, 1, 1'b1));
    repeat (3) @(negedge clk);
    m_cap = '0; m_cnt = 0; s_cnt = 0;
    miso_r = cpha ? 1'b0 : sw[0];
    mon_on = 1'b1;
    apb_write(A_TX, txw);
    repeat (4 * n + 30) @(negedge clk);
    mon_on = 1'b0;
    chk({tag, " R5 edge count"}, m_cnt, n);
    chk({tag, " R6 R7 data-out sequence"}, m_cap, wire_seq(txw, n, msb));
    apb_read(A_RX, d);
    chk({tag, " R6 R7 received word"}, d, rx_expect(sw, n, msb));
    chk({tag, " R2 idle level"}, {31'd0, sck}, {31'd0, cpol});
  endtask

  task automatic t_loop(input logic level);
    logic [31:0] d;
    miso_r = level;
    apply_mode(mk_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7, 0, 1'b1));
    apb_write(A_TX, 32'h0000_015A);
    repeat (60) @(negedge clk);
    apb_read(A_RX, d);
    chk($sformatf("R8 loopback ignores data-in=%0d", level), d, 32'h0000_005A);
  endtask

  task automatic t_div(input logic fast, input logic div16, input int pm);
    int t0, t1, half;
    logic [31:0] d;
    half = (fast ? 1 : 2) * (pm + 1) * (div16 ? 16 : 1);
    apply_mode(mk_mode(1'b1, 1'b0, 1'b0, div16, 1'b1, 1'b1, 3, pm, fast));
    apb_write(A_TX, 32'h5);
    @(posedge sck); t0 = cyc;
    @(posedge sck); t1 = cyc;
    chk($sformatf("R4 period fast=%0d div16=%0d pm=%0d", fast, div16, pm), t1 - t0, 2 * half);
    repeat (8 * half + 20) @(negedge clk);
    apb_read(A_RX, d);
    chk("R4 divided word intact", d, 32'h5);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    apply_mode(mk_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7, 1, 1'b0));
    apb_write(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 7, 5, 1'b1));
    apb_read(A_MODE, d);
    chk("R9 prescale/fast/div16 held", d & 32'h080F_2000, 32'h0001_0000);
    chk("R9 loop still written", {31'd0, d[30]}, 32'd1);
  endtask

  task automatic t_queue;
    logic [31:0] d;
    apply_mode(mk_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7, 0, 1'b1));
    for (int i = 0; i < 18; i++) apb_write(A_TX, 32'(i * 17 + 3));
    apb_write(A_EV, 32'h0000_0200);
    apb_read(A_EV, d);
    chk("R10 not-full flag stays clear when full", {31'd0, d[9]}, 32'd0);
    apb_write(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7, 0, 1'b1));
    repeat (17 * 24 + 40) @(negedge clk);
    apb_write(A_TX, 32'h0000_00EE);
    repeat (60) @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      apb_read(A_RX, d);
      chk($sformatf("R3 queued word %0d", i), d, 32'((i * 17 + 3) & 8'hFF));
    end
    apb_read(A_RX, d);
    chk("R3 overflow words dropped, empty read zero", d, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    apb_read(A_EV, d);
    chk("R10 last-word flag set", {31'd0, d[14]}, 32'd1);
    apb_write(A_MASK, 32'hFFFF_FFFF);
    apb_read(A_MASK, d);
    chk("R11 mask keeps event bits", d, 32'h0000_4300);
    apb_write(A_MASK, 32'h0000_4000);
    @(negedge clk);
    chk("R11 irq from last-word flag", {31'd0, irq}, 32'd1);
    apb_write(A_EV, 32'h0000_4100);
    apb_read(A_EV, d);
    chk("R10 write-1 clears flags 14 and 8", d & 32'h0000_4100, 32'h0);
    chk("R11 irq drops after clear", {31'd0, irq}, 32'd0);
    apb_write(A_MASK, 32'h0000_0200);
    @(negedge clk);
    chk("R11 irq from not-full flag", {31'd0, irq}, 32'd1);
    apb_write(A_MASK, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_xfer("mode0 msb 8b",  1'b0, 1'b0, 1'b1, 7,  32'h0000_00C5, 32'h0000_0096);
    run_xfer("mode3 lsb 32b", 1'b1, 1'b1, 1'b0, 0,  32'h1234_5678, 32'hDEAD_BEEF);
    run_xfer("mode1 msb 12b", 1'b0, 1'b1, 1'b1, 11, 32'h0000_FABC, 32'h0000_0A5C);
    run_xfer("mode2 lsb 5b",  1'b1, 1'b0, 1'b0, 4,  32'h0000_0013, 32'h0000_000B);
    t_loop(1'b1);
    t_loop(1'b0);
    t_div(1'b0, 1'b0, 1);
    t_div(1'b1, 1'b0, 2);
    t_div(1'b1, 1'b1, 0);
    t_div(1'b0, 1'b1, 3);
    t_lock();
    t_queue();
    t_events();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule